// File: doc/BRIEF.md
# Clock Output Divider with Encoded Ratio

This block derives an auxiliary clock output from the system clock. One 8-bit control register selects the behaviour. A 3-bit ratio code picks one of seven even division ratios or a straight pass-through of the input clock. A separate stop bit parks the output low. The output is meant for a pin or for a neighbouring block that needs a slower, related clock.

A new setting is applied only where it cannot cut a pulse short. In divided mode, a new ratio waits for the end of the high phase that is in progress. A stop request is honoured at once if the output is already low. The pass-through path is enabled and disabled by a flop on the falling input edge, so the output never moves while the input clock is high. A further register bit selects an extended register layout for the surrounding register file. This block only stores that bit and reports it.

Top module: `clkout_div`

## Requirements
- R1: While reset is asserted, clk_out is low and cfg_rdata reads 0. The register resets to 0, so after reset the output divides by 2.
- R2: With stop bit 0 and ratio code c in 0..6 (bits 2:0), the high and low phases of clk_out each last c+1 input cycles, for a period of 2*(c+1).
- R3: With stop bit 0 and ratio code 7, clk_out follows clk: it is high while clk is high and low while clk is low. The divided level is never high while the pass-through path is enabled.
- R4: With the stop bit (bit 3) set to 1, clk_out goes low at the latest at the end of the current high phase and then stays low, whatever the ratio code.
- R5: A write (cfg_we high at a rising clk edge) stores cfg_wdata. Bits 2:0, 3 and 7 read back as written. Bits 6:4 always read back 0.
- R6: layout_ext shows register bit 7 and has no effect on the division.
- R7: A ratio change written during a high phase lets that high phase finish at its old length. The following low phase already has the new length.
- R8: Leaving the stopped state into ratio code c gives a full low phase of c+1 cycles before the first high level. The first high level appears c+2 cycles after the edge that captures the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the source clock that is divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the control register |
| cfg_wdata | input | 8 | Write data: ratio code [2:0], stop [3], layout [7] |
| cfg_rdata | output | 8 | Current control register contents, reserved bits zero |
| layout_ext | output | 1 | Extended register layout select, reported only |
| clk_out | output | 1 | Divided, passed-through or stopped clock output |

## Verification
The bench targets the points where a ratio takes effect. A ratio written during a high phase must not shorten that phase; a design that reloads at once would give a runt high pulse or a low phase of the wrong length. Leaving the stopped state must start with a whole low phase, and an off-by-one in the counter shows up there as a first high level one cycle early or late. Code 7 is checked at both clock phases, because a design that treats it as a ratio of 16 or leaves the divided level active would fail the low-phase samples. The stop bit is checked with every code, and writes to bits 6:4 are checked to read back as zero.

// File: rtl/clkout_div_pkg.sv
package clkout_div_pkg;

    localparam int REG_W      = 8;
    localparam int CODE_W     = 3;
    localparam int STOP_BIT   = 3;
    localparam int LAYOUT_BIT = 7;

    typedef enum logic [1:0] {
        OM_STOP = 2'd0,
        OM_DIV  = 2'd1,
        OM_PASS = 2'd2
    } out_mode_e;

endpackage

// File: rtl/divcfg_reg.sv
module divcfg_reg #(
    parameter int REG_W      = clkout_div_pkg::REG_W,
    parameter int CODE_W     = clkout_div_pkg::CODE_W,
    parameter int STOP_BIT   = clkout_div_pkg::STOP_BIT,
    parameter int LAYOUT_BIT = clkout_div_pkg::LAYOUT_BIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] cfg_q
);

    logic [REG_W-1:0] keep_mask;
    logic [REG_W-1:0] cfg_d;
    logic [REG_W-1:0] cfg_r_q;

    // Only implemented fields hold state; the rest are tied to zero.
    for (genvar gi = 0; gi < REG_W; gi++) begin : g_mask
        assign keep_mask[gi] = (gi < CODE_W) || (gi == STOP_BIT) || (gi == LAYOUT_BIT);
    end

    always_comb begin
        cfg_d = cfg_r_q;
        if (wr_en) begin
            cfg_d = wr_data & keep_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_r_q <= '0;
        end else begin
            cfg_r_q <= cfg_d;
        end
    end

    assign cfg_q = cfg_r_q;

endmodule

// File: rtl/divcfg_decode.sv
module divcfg_decode
    import clkout_div_pkg::*;
#(
    parameter int REG_W    = clkout_div_pkg::REG_W,
    parameter int CODE_W   = clkout_div_pkg::CODE_W,
    parameter int STOP_BIT = clkout_div_pkg::STOP_BIT
) (
    input  logic [REG_W-1:0]  cfg,
    output out_mode_e         req_mode,
    output logic [CODE_W-1:0] req_code
);

    localparam logic [CODE_W-1:0] PASS_CODE = '1;

    always_comb begin
        req_code = cfg[CODE_W-1:0];
        if (cfg[STOP_BIT]) begin
            req_mode = OM_STOP;
        end else if (req_code == PASS_CODE) begin
            req_mode = OM_PASS;
        end else begin
            req_mode = OM_DIV;
        end
    end

endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
    import clkout_div_pkg::*;
#(
    parameter int CODE_W = clkout_div_pkg::CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  out_mode_e         req_mode,
    input  logic [CODE_W-1:0] req_code,
    output out_mode_e         act_mode,
    output logic [CODE_W-1:0] act_code,
    output logic              lvl
);

    typedef struct packed {
        out_mode_e         mode;
        logic [CODE_W-1:0] code;
        logic [CODE_W-1:0] cnt;
        logic              lvl;
    } core_st_t;

    localparam core_st_t ST_RESET = '{mode: OM_STOP, code: '0, cnt: '0, lvl: 1'b0};

    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.mode)
            OM_DIV: begin
                if (!st_q.lvl && req_mode == OM_STOP) begin
                    // Output already low: stopping here cannot clip a pulse.
                    st_d.mode = OM_STOP;
                    st_d.code = req_code;
                    st_d.cnt  = '0;
                end else if (st_q.cnt == st_q.code) begin
                    st_d.cnt = '0;
                    if (st_q.lvl) begin
                        // Falling edge of the output: the only point a ratio is swapped.
                        st_d.lvl  = 1'b0;
                        st_d.mode = req_mode;
                        st_d.code = req_code;
                    end else begin
                        st_d.lvl = 1'b1;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: begin
                // Stopped or passing through: divided level is low, load freely.
                st_d.mode = req_mode;
                st_d.code = req_code;
                st_d.cnt  = '0;
                st_d.lvl  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_mode = st_q.mode;
    assign act_code = st_q.code;
    assign lvl      = st_q.lvl;

endmodule

// File: rtl/clkout_div.sv
module clkout_div
    import clkout_div_pkg::*;
#(
    parameter int REG_W      = clkout_div_pkg::REG_W,
    parameter int CODE_W     = clkout_div_pkg::CODE_W,
    parameter int STOP_BIT   = clkout_div_pkg::STOP_BIT,
    parameter int LAYOUT_BIT = clkout_div_pkg::LAYOUT_BIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    output logic             layout_ext,
    output logic             clk_out
);

    logic [REG_W-1:0]  cfg_q;
    out_mode_e         req_mode;
    logic [CODE_W-1:0] req_code;
    out_mode_e         act_mode;
    logic [CODE_W-1:0] act_code;
    logic              div_lvl;
    logic              pass_en_d;
    logic              pass_en_q;

    divcfg_reg #(
        .REG_W      (REG_W),
        .CODE_W     (CODE_W),
        .STOP_BIT   (STOP_BIT),
        .LAYOUT_BIT (LAYOUT_BIT)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .cfg_q   (cfg_q)
    );

    divcfg_decode #(
        .REG_W    (REG_W),
        .CODE_W   (CODE_W),
        .STOP_BIT (STOP_BIT)
    ) u_dec (
        .cfg      (cfg_q),
        .req_mode (req_mode),
        .req_code (req_code)
    );

    clkdiv_core #(
        .CODE_W (CODE_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_mode (req_mode),
        .req_code (req_code),
        .act_mode (act_mode),
        .act_code (act_code),
        .lvl      (div_lvl)
    );

    // Pass-through select moves on the falling input edge, while clk is low.
    always_comb begin
        pass_en_d = (act_mode == OM_PASS);
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pass_en_q <= 1'b0;
        end else begin
            pass_en_q <= pass_en_d;
        end
    end

    assign clk_out    = pass_en_q ? clk : div_lvl;
    assign cfg_rdata  = cfg_q;
    assign layout_ext = cfg_q[LAYOUT_BIT];

endmodule

// File: rtl/clkout_div_chk.sv
module clkout_div_chk #(
    parameter int REG_W    = clkout_div_pkg::REG_W,
    parameter int CODE_W   = clkout_div_pkg::CODE_W,
    parameter int STOP_BIT = clkout_div_pkg::STOP_BIT
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_W-1:0]  cfg_rdata,
    input logic              div_lvl,
    input logic              pass_en_q,
    input logic [CODE_W-1:0] act_code
);

    // R5: unimplemented bits never read back as one
    a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[6:4] == 3'b000);

    // R4: a stop request seen while low keeps the divided level low
    a_r4_stop_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_rdata[STOP_BIT]) && !$past(div_lvl)) |-> !div_lvl);

    // R7: the active ratio only changes when the divided level is low
    a_r7_switch_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_code) |-> !div_lvl);

    // R3: pass-through and divided paths are never active together
    a_r3_paths_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_en_q && div_lvl));

endmodule

bind clkout_div clkout_div_chk #(
    .REG_W    (REG_W),
    .CODE_W   (CODE_W),
    .STOP_BIT (STOP_BIT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_rdata (cfg_rdata),
    .div_lvl   (div_lvl),
    .pass_en_q (pass_en_q),
    .act_code  (act_code)
);

// File: tb/tb_clkout_div.sv
module tb_clkout_div;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       layout_ext;
    logic       clk_out;

    int n_chk = 0;
    int n_fail = 0;

    clkout_div dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .layout_ext (layout_ext),
        .clk_out    (clk_out)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic int exp_half(input logic [2:0] code);
        return int'(code) + 1;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] w);
        return w & 8'h8F;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic lo_sample(output logic v);
        @(negedge clk);
        #(CLK_P/4);
        v = clk_out;
    endtask

    task automatic hi_sample(output logic v);
        @(posedge clk);
        #(CLK_P/4);
        v = clk_out;
    endtask

    // Called at a low-phase sample point; returns at the sample after capture.
    task automatic write_cfg(input logic [7:0] d);
        cfg_we    = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        #(CLK_P/4);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        logic v;
        for (int i = 0; i < n; i++) lo_sample(v);
    endtask

    // Measure one low run and one high run of the divided output.
    task automatic measure_div(input int h, input string req);
        logic prev, cur;
        int lo_n, hi_n, guard;
        lo_sample(prev);
        guard = 0;
        lo_sample(cur);
        while (!(prev == 1'b1 && cur == 1'b0) && guard < 64) begin
            prev = cur;
            lo_sample(cur);
            guard++;
        end
        lo_n = 0;
        while (cur == 1'b0 && lo_n < 40) begin
            lo_n++;
            lo_sample(cur);
        end
        hi_n = 0;
        while (cur == 1'b1 && hi_n < 40) begin
            hi_n++;
            lo_sample(cur);
        end
        chk(lo_n == h, {req, " low phase"}, lo_n, h);
        chk(hi_n == h, {req, " high phase"}, hi_n, h);
    endtask

    task automatic check_pass(input string req);
        logic vh, vl;
        int bad;
        bad = 0;
        for (int i = 0; i < 6; i++) begin
            hi_sample(vh);
            lo_sample(vl);
            if (vh !== 1'b1 || vl !== 1'b0) bad++;
        end
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic check_stopped(input string req);
        logic vh, vl;
        int ones;
        ones = 0;
        for (int i = 0; i < 20; i++) begin
            hi_sample(vh);
            lo_sample(vl);
            if (vh !== 1'b0) ones++;
            if (vl !== 1'b0) ones++;
        end
        chk(ones == 0, req, ones, 0);
    endtask

    task automatic apply_and_check(input logic [7:0] w);
        write_cfg(w);
        chk(cfg_rdata == exp_rd(w), "R5 readback", int'(cfg_rdata), int'(exp_rd(w)));
        chk(layout_ext == w[7], "R6 layout bit", int'(layout_ext), int'(w[7]));
        idle(34);
        if (w[3]) check_stopped("R4 stopped output");
        else if (w[2:0] == 3'd7) check_pass("R3 pass-through");
        else measure_div(exp_half(w[2:0]), "R2 divided");
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic v, vh;
        int seed, cnt, hi_n, lo_n;
        logic [7:0] w;
        seed = 32'h5EED_0C1D;
        void'($urandom(seed));

        // R1: reset state
        idle(2);
        hi_sample(vh);
        lo_sample(v);
        chk(vh == 1'b0 && v == 1'b0, "R1 clk_out low in reset", int'({vh, v}), 0);
        chk(cfg_rdata == 8'h00, "R1 register reset value", int'(cfg_rdata), 0);
        rst_n = 1'b1;
        measure_div(1, "R1 divide by 2 after reset");

        // R2: every even ratio, directed
        for (int c = 0; c < 7; c++) apply_and_check(8'(c));

        // R3: pass-through, also with layout bit set
        apply_and_check(8'h07);
        apply_and_check(8'h87);

        // R4: stop with several codes, including pass code
        apply_and_check(8'h08);
        apply_and_check(8'h0F);
        apply_and_check(8'h0D);

        // R8: leave stopped state into code 3: h zeros after the capture sample
        write_cfg(8'h03);
        cnt = 0;
        lo_sample(v);
        while (v == 1'b0 && cnt < 40) begin
            cnt++;
            lo_sample(v);
        end
        chk(cnt == 4, "R8 first low phase after stop", cnt, 4);

        // R7: change ratio 4 -> 2 during a high phase (old half 4, new half 2)
        write_cfg(8'h03);
        idle(34);
        lo_sample(v);
        cnt = 0;
        while (v != 1'b0 && cnt < 40) begin lo_sample(v); cnt++; end
        while (v != 1'b1 && cnt < 80) begin lo_sample(v); cnt++; end
        cfg_we = 1'b1;
        cfg_wdata = 8'h01;
        hi_n = 1;
        lo_sample(v);
        cfg_we = 1'b0;
        while (v == 1'b1 && hi_n < 40) begin hi_n++; lo_sample(v); end
        lo_n = 0;
        while (v == 1'b0 && lo_n < 40) begin lo_n++; lo_sample(v); end
        chk(hi_n == 4, "R7 high phase keeps old length", hi_n, 4);
        chk(lo_n == 2, "R7 next low phase uses new length", lo_n, 2);

        // R5/R6: reserved bits and layout bit do not disturb the ratio
        apply_and_check(8'hF2);
        apply_and_check(8'h75);

        // Random settings from a fixed seed
        for (int k = 0; k < 24; k++) begin
            w = 8'($urandom);
            if (($urandom % 4) != 0) w[3] = 1'b0;
            apply_and_check(w);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule